// File: doc/BRIEF.md
# FIS DMA Control and Status Registers

This block is the register front end that a CPU uses to steer a SATA host DMA engine. It sits on a simple bus where each access takes one cycle. Through it the CPU loads three memory base addresses: one for outgoing frames, one for incoming non-data frames and one for incoming data frames. It also loads a control word that starts an outgoing transfer or pulses a hardware reset. The DMA datapaths stay outside the block. They see the stored addresses and control fields as outputs. They report back through single-cycle strobes for transfer completion, received words, received frame type and error codes.

The read side and the write side decode the bus offsets differently. A read at offset 0x04 returns the error word, while a write there loads the non-data receive address. A read at 0x0C returns the receive count and the frame type, while a write there loads the data receive address. Any control write clears the received word count. The interrupt-clear register drops the two completion interrupts and the latched frame type. An address that is not 512-byte aligned is trimmed, and a sticky flag records it. A start request that arrives while the engine is busy is refused, and a second sticky flag records that.

Top module: `fis_dma_regs`

## Requirements
- R1: After reset every output is zero, and reads of offsets 0x04 and 0x0C return 0.
- R2: A write at offset 0x00, 0x04 or 0x0C loads the transmit, non-data receive or data receive address. The new value shows on its output in the cycle after the write, with bits 8:0 forced to zero.
- R3: An address write whose bits 8:0 are not all zero sets bit 16 of the error word (read at offset 0x04). The bit stays set until a control write with bit 31 set. An aligned address write leaves it clear.
- R4: A write at offset 0x08 with bit 30 set while tx_busy is low produces a tx_start pulse for exactly one cycle, in the cycle after the write. The same write loads tx_is_data from bit 29 (1 means data frame) and tx_len from bits 15:0.
- R5: A control write with bit 30 set while tx_busy is high is refused. No tx_start pulse follows, and tx_is_data and tx_len keep their values. Bit 17 of the error word is set, and it is cleared the same way as bit 16.
- R6: A control write with bit 31 set pulses hw_reset for one cycle and clears error word bits 17:16. Error word bits 7:0 are kept.
- R7: Each rx_word strobe adds one to the received word count, read in bits 23:0 at offset 0x0C. Any write to offset 0x08 clears the count, and the clear wins over a strobe in the same cycle.
- R8: Bit 31 at offset 0x0C takes rx_type_nondata on each rx_type_vld strobe (1 means non-data frame, 0 means data frame). It holds until a write at offset 0x10 with bit 29 set. A strobe in the same cycle as that clear wins.
- R9: rx_done sets irq_d2h and tx_done sets irq_h2d. A write at offset 0x10 with bit 31 set clears irq_d2h, and one with bit 30 set clears irq_h2d. A done pulse in the same cycle as its clear wins.
- R10: err_vld captures err_code into bits 7:0 of the error word. Read data is registered and appears in the cycle after the read strobe. Any other read offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_busy | input | 1 | Transmit engine busy |
| tx_done | input | 1 | Host-to-device completion pulse |
| rx_done | input | 1 | Device-to-host completion pulse |
| rx_word | input | 1 | One received word strobe |
| rx_type_vld | input | 1 | Received frame type strobe |
| rx_type_nondata | input | 1 | Frame type with the strobe, 1 means non-data |
| err_vld | input | 1 | Error code strobe |
| err_code | input | ERR_W | Error code from the link side |
| tx_addr | output | MAW | Transmit base address |
| rxf_addr | output | MAW | Non-data receive base address |
| rxd_addr | output | MAW | Data receive base address |
| tx_start | output | 1 | One-cycle start pulse |
| tx_is_data | output | 1 | Transfer is a data frame |
| tx_len | output | LEN_W | Transmit word count |
| hw_reset | output | 1 | One-cycle hardware reset pulse |
| irq_d2h | output | 1 | Device-to-host interrupt |
| irq_h2d | output | 1 | Host-to-device interrupt |

## Verification
Every result is due one cycle after its stimulus. The address outputs, the control fields, the tx_start and hw_reset pulses and the interrupts are all registered on the edge that takes the write or strobe. Read data is registered on the edge that takes the read strobe. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each result is checked half a period after the edge that made it. Each pulse is then checked again one period later to confirm that it has dropped. Expected read words wait in a queue until the monitor sees the cycle after each read strobe.

// File: rtl/fis_regs_pkg.sv
package fis_regs_pkg;
  localparam int OFS_W = 5;

  // write-side decode
  localparam logic [OFS_W-1:0] WOFS_TXA  = 5'h00;
  localparam logic [OFS_W-1:0] WOFS_RXF  = 5'h04;
  localparam logic [OFS_W-1:0] WOFS_CTRL = 5'h08;
  localparam logic [OFS_W-1:0] WOFS_RXD  = 5'h0C;
  localparam logic [OFS_W-1:0] WOFS_ICLR = 5'h10;

  // read-side decode
  localparam logic [OFS_W-1:0] ROFS_ERR  = 5'h04;
  localparam logic [OFS_W-1:0] ROFS_STAT = 5'h0C;

  // bit positions
  localparam int CB_HWRST  = 31;
  localparam int CB_START  = 30;
  localparam int CB_ISDATA = 29;
  localparam int IB_D2H    = 31;
  localparam int IB_H2D    = 30;
  localparam int IB_TYPE   = 29;
  localparam int EB_MIS    = 16;
  localparam int EB_BUSY   = 17;
  localparam int SB_TYPE   = 31;

  localparam int NUM_ADDR = 3;
  localparam int NUM_IRQ  = 2;
  localparam int IRQ_D2H  = 0;
  localparam int IRQ_H2D  = 1;

  typedef struct packed {
    logic        hw_reset;
    logic        start;
    logic        is_data;
    logic [15:0] len;
  } ctrl_word_t;

  function automatic ctrl_word_t unpack_ctrl(input logic [31:0] w);
    ctrl_word_t c;
    c.hw_reset = w[CB_HWRST];
    c.start    = w[CB_START];
    c.is_data  = w[CB_ISDATA];
    c.len      = w[15:0];
    return c;
  endfunction
endpackage

// File: rtl/fis_addr_reg.sv
module fis_addr_reg #(
  parameter int AW    = 32,
  parameter int ALIGN = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic          misalign
);
  localparam int HI_W = AW - ALIGN;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)     hi_q <= '0;
    else if (we) hi_q <= wdata[AW-1:ALIGN];
  end

  assign addr_q   = {hi_q, {ALIGN{1'b0}}};
  assign misalign = we && (|wdata[ALIGN-1:0]);
endmodule

// File: rtl/fis_irq_ctl.sv
module fis_irq_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)         irq[i] <= 1'b0;
      else if (set[i]) irq[i] <= 1'b1;
      else if (clr[i]) irq[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fis_rx_status.sv
module fis_rx_status #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  input  logic             cnt_clr,
  input  logic             type_vld,
  input  logic             type_nondata,
  input  logic             type_clr,
  output logic [CNT_W-1:0] count,
  output logic             fis_type
);
  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (cnt_clr)  count <= '0;
    else if (word_stb) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           fis_type <= 1'b0;
    else if (type_vld) fis_type <= type_nondata;
    else if (type_clr) fis_type <= 1'b0;
  end
endmodule

// File: rtl/fis_dma_regs.sv
module fis_dma_regs
  import fis_regs_pkg::*;
#(
  parameter int MAW   = 32,
  parameter int ALIGN = 9,
  parameter int LEN_W = 16,
  parameter int CNT_W = 24,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             tx_busy,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             rx_word,
  input  logic             rx_type_vld,
  input  logic             rx_type_nondata,
  input  logic             err_vld,
  input  logic [ERR_W-1:0] err_code,
  output logic [MAW-1:0]   tx_addr,
  output logic [MAW-1:0]   rxf_addr,
  output logic [MAW-1:0]   rxd_addr,
  output logic             tx_start,
  output logic             tx_is_data,
  output logic [LEN_W-1:0] tx_len,
  output logic             hw_reset,
  output logic             irq_d2h,
  output logic             irq_h2d
);
  // write decode
  logic wr_ctrl, wr_iclr;
  logic [NUM_ADDR-1:0] wr_addr_sel;
  logic [NUM_ADDR-1:0] mis_hit;
  logic [MAW-1:0]      addr_q [NUM_ADDR];

  assign wr_ctrl        = bus_wr && (bus_addr == WOFS_CTRL);
  assign wr_iclr        = bus_wr && (bus_addr == WOFS_ICLR);
  assign wr_addr_sel[0] = bus_wr && (bus_addr == WOFS_TXA);
  assign wr_addr_sel[1] = bus_wr && (bus_addr == WOFS_RXF);
  assign wr_addr_sel[2] = bus_wr && (bus_addr == WOFS_RXD);

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr
    fis_addr_reg #(.AW(MAW), .ALIGN(ALIGN)) u_areg (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_addr_sel[i]),
      .wdata    (bus_wdata[MAW-1:0]),
      .addr_q   (addr_q[i]),
      .misalign (mis_hit[i])
    );
  end

  assign tx_addr  = addr_q[0];
  assign rxf_addr = addr_q[1];
  assign rxd_addr = addr_q[2];

  // control word handling
  ctrl_word_t cw;
  logic start_ok, start_rej, hwrst_req;

  assign cw        = unpack_ctrl(bus_wdata);
  assign start_ok  = wr_ctrl && cw.start && !tx_busy;
  assign start_rej = wr_ctrl && cw.start && tx_busy;
  assign hwrst_req = wr_ctrl && cw.hw_reset;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start   <= 1'b0;
      hw_reset   <= 1'b0;
      tx_is_data <= 1'b0;
      tx_len     <= '0;
    end else begin
      tx_start <= start_ok;
      hw_reset <= hwrst_req;
      if (wr_ctrl && !start_rej) begin
        tx_is_data <= cw.is_data;
        tx_len     <= cw.len[LEN_W-1:0];
      end
    end
  end

  // sticky error flags and captured error code
  logic             mis_flag, busy_flag;
  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_flag  <= 1'b0;
      busy_flag <= 1'b0;
      err_q     <= '0;
    end else begin
      if (|mis_hit)       mis_flag <= 1'b1;
      else if (hwrst_req) mis_flag <= 1'b0;
      if (start_rej)      busy_flag <= 1'b1;
      else if (hwrst_req) busy_flag <= 1'b0;
      if (err_vld)        err_q <= err_code;
    end
  end

  // receive status
  logic [CNT_W-1:0] rx_cnt;
  logic             rx_type_q;

  fis_rx_status #(.CNT_W(CNT_W)) u_rxs (
    .clk          (clk),
    .rst          (rst),
    .word_stb     (rx_word),
    .cnt_clr      (wr_ctrl),
    .type_vld     (rx_type_vld),
    .type_nondata (rx_type_nondata),
    .type_clr     (wr_iclr && bus_wdata[IB_TYPE]),
    .count        (rx_cnt),
    .fis_type     (rx_type_q)
  );

  // interrupts
  logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_q;

  assign irq_set[IRQ_D2H] = rx_done;
  assign irq_set[IRQ_H2D] = tx_done;
  assign irq_clr[IRQ_D2H] = wr_iclr && bus_wdata[IB_D2H];
  assign irq_clr[IRQ_H2D] = wr_iclr && bus_wdata[IB_H2D];

  fis_irq_ctl #(.N(NUM_IRQ)) u_irq (
    .clk (clk),
    .rst (rst),
    .set (irq_set),
    .clr (irq_clr),
    .irq (irq_q)
  );

  assign irq_d2h = irq_q[IRQ_D2H];
  assign irq_h2d = irq_q[IRQ_H2D];

  // read decode, registered
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      ROFS_ERR: begin
        rd_word[ERR_W-1:0] = err_q;
        rd_word[EB_MIS]    = mis_flag;
        rd_word[EB_BUSY]   = busy_flag;
      end
      ROFS_STAT: begin
        rd_word[CNT_W-1:0] = rx_cnt;
        rd_word[SB_TYPE]   = rx_type_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/fis_dma_regs_chk.sv
module fis_dma_regs_chk
  import fis_regs_pkg::*;
#(
  parameter int MAW   = 32,
  parameter int ALIGN = 9,
  parameter int LEN_W = 16,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [OFS_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             tx_busy,
  input logic             tx_done,
  input logic             rx_done,
  input logic [MAW-1:0]   tx_addr,
  input logic             tx_start,
  input logic [LEN_W-1:0] tx_len,
  input logic             hw_reset,
  input logic             irq_d2h,
  input logic             irq_h2d,
  input logic [CNT_W-1:0] rx_cnt
);
  // R2
  txa_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WOFS_TXA) |=>
      (tx_addr[MAW-1:ALIGN] == $past(bus_wdata[MAW-1:ALIGN])) && (tx_addr[ALIGN-1:0] == '0));

  // R4
  start_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WOFS_CTRL && bus_wdata[CB_START] && !tx_busy) |=> tx_start);

  // R4
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == WOFS_CTRL) |=> (!tx_start && !hw_reset));

  // R5
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WOFS_CTRL && bus_wdata[CB_START] && tx_busy) |=>
      (!tx_start && $stable(tx_len)));

  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WOFS_CTRL) |=> (rx_cnt == '0));

  // R9
  d2h_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> irq_d2h);

  // R9
  h2d_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> irq_h2d);

  // R9
  d2h_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WOFS_ICLR && bus_wdata[IB_D2H] && !rx_done) |=> !irq_d2h);
endmodule

bind fis_dma_regs fis_dma_regs_chk #(
  .MAW(MAW), .ALIGN(ALIGN), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .tx_busy   (tx_busy),
  .tx_done   (tx_done),
  .rx_done   (rx_done),
  .tx_addr   (tx_addr),
  .tx_start  (tx_start),
  .tx_len    (tx_len),
  .hw_reset  (hw_reset),
  .irq_d2h   (irq_d2h),
  .irq_h2d   (irq_h2d),
  .rx_cnt    (rx_cnt)
);

// File: tb/sim_fis_dma_regs.sv
`timescale 1ns/1ps
module sim_fis_dma_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tx_busy, tx_done, rx_done, rx_word, rx_type_vld, rx_type_nondata, err_vld;
  logic [7:0]  err_code;
  logic [31:0] tx_addr, rxf_addr, rxd_addr;
  logic        tx_start, tx_is_data, hw_reset, irq_d2h, irq_h2d;
  logic [15:0] tx_len;

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_q;

  always #2.5 clk = ~clk;

  fis_dma_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_done(rx_done), .rx_word(rx_word), .rx_type_vld(rx_type_vld),
    .rx_type_nondata(rx_type_nondata), .err_vld(err_vld), .err_code(err_code),
    .tx_addr(tx_addr), .rxf_addr(rxf_addr), .rxd_addr(rxd_addr), .tx_start(tx_start),
    .tx_is_data(tx_is_data), .tx_len(tx_len), .hw_reset(hw_reset),
    .irq_d2h(irq_d2h), .irq_h2d(irq_h2d)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read data is valid in the cycle after the read strobe
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q === 1'b1 && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nchk++;
      if (bus_rdata !== e) begin
        nfail++;
        $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bread(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tx_busy = 0; tx_done = 0; rx_done = 0; rx_word = 0; rx_type_vld = 0;
    rx_type_nondata = 0; err_vld = 0; err_code = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_addr", tx_addr, 0);
    chk("R1 rxd_addr", rxd_addr, 0);
    chk("R1 outs", {tx_start, tx_is_data, hw_reset, irq_d2h, irq_h2d, 16'(tx_len)}, 0);
    bread(5'h04, 32'h0, "R1 err");
    bread(5'h0C, 32'h0, "R1 stat");

    // R2 aligned addresses
    bwrite(5'h00, 32'h8000_0000); chk("R2 tx_addr", tx_addr, 32'h8000_0000);
    bwrite(5'h04, 32'h8000_1000); chk("R2 rxf_addr", rxf_addr, 32'h8000_1000);
    bwrite(5'h0C, 32'h8300_0000); chk("R2 rxd_addr", rxd_addr, 32'h8300_0000);
    bread(5'h04, 32'h0, "R3 aligned no flag");

    // R2/R3 misaligned
    bwrite(5'h00, 32'h1234_5678); chk("R2 trim", tx_addr, 32'h1234_5600);
    bread(5'h04, 32'h0001_0000, "R3 misalign flag");

    // R6 hw reset
    bwrite(5'h08, 32'h8000_0000);
    chk("R6 pulse", hw_reset, 1);
    @(negedge clk); chk("R6 pulse drop", hw_reset, 0);
    bread(5'h04, 32'h0, "R6 flags cleared");

    // R4 start
    bwrite(5'h08, 32'h6000_0010);
    chk("R4 start", tx_start, 1);
    chk("R4 fields", {tx_is_data, tx_len}, {1'b1, 16'h0010});
    @(negedge clk); chk("R4 start drop", tx_start, 0);

    // R5 busy refuse
    tx_busy = 1;
    bwrite(5'h08, 32'h4000_0020);
    chk("R5 no start", tx_start, 0);
    chk("R5 fields kept", {tx_is_data, tx_len}, {1'b1, 16'h0010});
    tx_busy = 0;
    bread(5'h04, 32'h0002_0000, "R5 busy flag");

    // R7 count
    rx_word = 1; repeat (5) @(negedge clk); rx_word = 0;
    bread(5'h0C, 32'd5, "R7 count");
    bwrite(5'h08, 32'h0);
    bread(5'h0C, 32'd0, "R7 cleared");
    rx_word = 1; repeat (3) @(negedge clk);
    bwrite(5'h08, 32'h0); rx_word = 0;
    bread(5'h0C, 32'd0, "R7 clear wins");

    // R8 frame type
    rx_type_vld = 1; rx_type_nondata = 1; @(negedge clk); rx_type_vld = 0;
    bread(5'h0C, 32'h8000_0000, "R8 nondata");
    bwrite(5'h10, 32'h4000_0000);
    bread(5'h0C, 32'h8000_0000, "R8 kept");
    bwrite(5'h10, 32'h2000_0000);
    bread(5'h0C, 32'h0, "R8 cleared");
    rx_type_vld = 1; rx_type_nondata = 1;
    bwrite(5'h10, 32'h2000_0000); rx_type_vld = 0;
    bread(5'h0C, 32'h8000_0000, "R8 capture wins");
    rx_type_vld = 1; rx_type_nondata = 0; @(negedge clk); rx_type_vld = 0;
    bread(5'h0C, 32'h0, "R8 data type");

    // R9 interrupts
    rx_done = 1; @(negedge clk); rx_done = 0;
    chk("R9 d2h set", {irq_d2h, irq_h2d}, 2'b10);
    tx_done = 1; @(negedge clk); tx_done = 0;
    chk("R9 h2d set", {irq_d2h, irq_h2d}, 2'b11);
    bwrite(5'h10, 32'h8000_0000);
    chk("R9 d2h clr", {irq_d2h, irq_h2d}, 2'b01);
    tx_done = 1; bwrite(5'h10, 32'h4000_0000); tx_done = 0;
    chk("R9 set wins", irq_h2d, 1);
    bwrite(5'h10, 32'h4000_0000);
    chk("R9 h2d clr", irq_h2d, 0);

    // R10 error code, read decode
    err_vld = 1; err_code = 8'hA5; @(negedge clk); err_vld = 0;
    bread(5'h04, 32'h0002_00A5, "R10 err code");
    bwrite(5'h08, 32'h8000_0000);
    bread(5'h04, 32'h0000_00A5, "R6 code kept");
    bread(5'h08, 32'h0, "R10 unmapped 08");
    bread(5'h14, 32'h0, "R10 unmapped 14");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule